// File: doc/BRIEF.md
# Frame-Sync Presentation Timestamp Queue

This block keeps the presentation timestamps for frame-sync events in an isochronous transmit and receive path. On the transmit side, each application frame-sync pulse is stamped with the local cycle time moved a programmable number of 125 µs bus cycles into the future. The stamp is held in a small FIFO. At every isochronous cycle start, the oldest stamp is placed on `syt_out` for the packet header builder. When nothing is due, the no-info code 0xFFFF is placed there instead.

In audio mode a stamp leaves the queue only on cycles that carry application data, and two more cycles are added to the programmed delay. If a pulse arrives while the queue is full, the whole queue is flushed and a one-clock overflow pulse is raised. Normal queuing then continues.

On the receive side, a timestamp taken from an incoming header is loaded and armed. When the local cycle timer reaches that value, a single frame-sync pulse is regenerated. This pulse depends only on the system clock and the cycle timer.

Top module: `syt_queue`

## Requirements
- R1: Reset state: `syt_out` is 0xFFFF, `ovf_pulse` is 0 and `fsync_out` is 0, and the queue is empty.
- R2: A pulse on `fsync_in` queues the value {(C + D) mod 16, O}. C (4 bits) and O (12 bits) are the `cyc_count` and `cyc_offset` values presented in the previous clock. D is 2 when `delay_sel` = 01, 4 when it is 10, and 3 when it is 00 or 11.
- R3: Stamps leave in arrival order. On a clock with `cyc_start` high, `syt_out` loads the oldest stamp, or 0xFFFF if the queue is empty. It holds that value until the next `cyc_start`. The queue holds at most 8 stamps.
- R4: With `audio_mode` low, a pending stamp is emitted on every cycle start, whatever the value of `cyc_has_data`.
- R5: With `audio_mode` high, D is increased by 2. A stamp is emitted only at a cycle start where `cyc_has_data` is high. Any other cycle start outputs 0xFFFF and keeps the queue unchanged.
- R6: A pulse that finds 8 stamps queued, at a clock with no emission, has these effects: the queue is emptied, the pulse is discarded, and `ovf_pulse` is high for one clock. Later pulses are then queued normally.
- R7: A value loaded through `rx_syt_load` arms the receiver. `fsync_out` goes high for exactly one clock, in the clock after {`cyc_count`,`cyc_offset`} first equals the armed value. The receiver then disarms.
- R8: Loading 0xFFFF disarms the receiver, and no `fsync_out` pulse follows, even when the timer shows 0xFFFF.
- R9: A pulse that arrives in the same clock as `cyc_start` is stamped with the cycle time from before the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_count | input | 4 | Low bits of the local bus cycle count |
| cyc_offset | input | 12 | Local cycle offset, 0 to 3071 |
| cyc_start | input | 1 | Isochronous cycle boundary strobe |
| cyc_has_data | input | 1 | Current cycle carries application data |
| delay_sel | input | 2 | Stamp delay selection |
| audio_mode | input | 1 | Audio emission mode |
| fsync_in | input | 1 | Application frame-sync pulse |
| syt_out | output | 16 | Timestamp for the current cycle's header |
| ovf_pulse | output | 1 | One-clock queue overflow indication |
| rx_syt | input | 16 | Received header timestamp |
| rx_syt_load | input | 1 | Load strobe for `rx_syt` |
| fsync_out | output | 1 | Regenerated receive frame-sync pulse |

## Verification
The assertions check these properties on every cycle:
- the fill level never exceeds the depth;
- an overflow always leaves the queue empty and always follows a frame-sync pulse;
- `syt_out` changes only at a cycle start;
- an audio cycle start without data emits no-info;
- `fsync_out` never lasts two clocks;
- a no-info load leaves the receiver disarmed.

Only the bench scenarios can show the following:
- that stamp values are computed correctly for each delay setting and in audio mode;
- that FIFO order is kept across many cycles;
- that a pulse coinciding with a boundary uses the earlier cycle time;
- that queuing resumes correctly after a flush;
- that the receive pulse appears at exactly the matching timer value.

// File: rtl/syt_queue.sv
module syt_queue #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int OFS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       cyc_count,
  input  logic [OFS_W-1:0]       cyc_offset,
  input  logic                   cyc_start,
  input  logic                   cyc_has_data,
  input  logic [1:0]             delay_sel,
  input  logic                   audio_mode,
  input  logic                   fsync_in,
  output logic [CNT_W+OFS_W-1:0] syt_out,
  output logic                   ovf_pulse,
  input  logic [CNT_W+OFS_W-1:0] rx_syt,
  input  logic                   rx_syt_load,
  output logic                   fsync_out
);
  localparam int SYT_W = CNT_W + OFS_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0]   FULL   = (PTR_W+1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);
  localparam logic [SYT_W-1:0] NOINFO = '1;

  logic [SYT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   fill;
  logic [SYT_W-1:0] prev_time, rx_target;
  logic             rx_armed;
  logic [CNT_W-1:0] delay;

  always_comb begin
    case (delay_sel)
      2'b01:   delay = CNT_W'(2);
      2'b10:   delay = CNT_W'(4);
      default: delay = CNT_W'(3);
    endcase
  end

  wire [SYT_W-1:0] now_time = {cyc_count, cyc_offset};
  wire [CNT_W-1:0] shift    = delay + (audio_mode ? CNT_W'(2) : CNT_W'(0));
  wire [SYT_W-1:0] stamp    = {prev_time[SYT_W-1:OFS_W] + shift, prev_time[OFS_W-1:0]};
  wire             pop      = cyc_start && (fill != '0) && (!audio_mode || cyc_has_data);
  wire             room     = (fill != FULL) || pop;
  wire             push     = fsync_in && room;
  wire             ovf      = fsync_in && !room;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= stamp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fill      <= '0;
      prev_time <= '0;
      syt_out   <= NOINFO;
      ovf_pulse <= 1'b0;
    end else begin
      prev_time <= now_time;
      ovf_pulse <= ovf;
      if (cyc_start) syt_out <= pop ? mem[rd_ptr] : NOINFO;
      if (ovf) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        fill   <= '0;
      end else begin
        if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        fill <= fill + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_armed  <= 1'b0;
      rx_target <= NOINFO;
      fsync_out <= 1'b0;
    end else begin
      fsync_out <= rx_armed && (now_time == rx_target);
      if (rx_armed && (now_time == rx_target)) rx_armed <= 1'b0;
      if (rx_syt_load) begin
        rx_target <= rx_syt;
        rx_armed  <= (rx_syt != NOINFO);
      end
    end
  end
endmodule

// File: rtl/syt_queue_chk.sv
module syt_queue_chk #(
  parameter int DEPTH = 8,
  parameter int FW    = 4,
  parameter int SYT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start,
  input logic             cyc_has_data,
  input logic             audio_mode,
  input logic             fsync_in,
  input logic [SYT_W-1:0] syt_out,
  input logic             ovf_pulse,
  input logic [SYT_W-1:0] rx_syt,
  input logic             rx_syt_load,
  input logic             fsync_out,
  input logic [FW-1:0]    fill,
  input logic             rx_armed
);
  localparam logic [SYT_W-1:0] NOINFO = '1;

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
  p_hold_between_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(syt_out));
  p_audio_idle_noinfo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_mode && cyc_start && !cyc_has_data) |=> (syt_out == NOINFO));
  p_no_overflow_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (fill == '0));
  p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(fsync_in));
  p_single_fsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |=> !fsync_out);
  p_noinfo_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_syt_load && rx_syt == NOINFO) |=> !rx_armed);
endmodule

bind syt_queue syt_queue_chk #(.DEPTH(DEPTH), .FW(PTR_W+1), .SYT_W(SYT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_has_data(cyc_has_data),
  .audio_mode(audio_mode), .fsync_in(fsync_in), .syt_out(syt_out),
  .ovf_pulse(ovf_pulse), .rx_syt(rx_syt), .rx_syt_load(rx_syt_load),
  .fsync_out(fsync_out), .fill(fill), .rx_armed(rx_armed));

// File: tb/syt_queue_tb_top.sv
module syt_queue_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cnt = '0;
  logic [11:0] ofs = '0;
  logic cs = 0, hd = 0, aud = 0, fs = 0, ld = 0;
  logic [1:0] dsel = 2'b00;
  logic [15:0] rx = '0;
  logic [15:0] syt_out;
  logic ovf_pulse, fsync_out;

  int total = 0, bad = 0;
  logic [15:0] q [8];
  int qn = 0;
  logic [15:0] e_syt = 16'hFFFF, last_t = '0, tgt = 16'hFFFF;
  bit e_ovf = 0, e_fs = 0, armed = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  syt_queue dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_count(cnt), .cyc_offset(ofs),
    .cyc_start(cs), .cyc_has_data(hd), .delay_sel(dsel), .audio_mode(aud),
    .fsync_in(fs), .syt_out(syt_out), .ovf_pulse(ovf_pulse),
    .rx_syt(rx), .rx_syt_load(ld), .fsync_out(fsync_out));

  function automatic logic [15:0] stamp_f(logic [15:0] t, logic [1:0] sel, bit a);
    logic [3:0] d;
    d = (sel == 2'b01) ? 4'd2 : (sel == 2'b10) ? 4'd4 : 4'd3;
    if (a) d = d + 4'd2;
    return {t[15:12] + d, t[11:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv(int inc);
    int o;
    o = int'(ofs) + inc;
    cs = 0;
    if (o > 3071) begin
      o = o - 3072;
      cnt = cnt + 4'd1;
      cs = 1;
    end
    ofs = 12'(o);
  endtask

  task automatic step(string tag);
    bit pop;
    pop = cs && qn > 0 && (!aud || hd);
    if (cs) e_syt = pop ? q[0] : 16'hFFFF;
    if (pop) begin
      for (int i = 0; i < 7; i++) q[i] = q[i+1];
      qn--;
    end
    e_ovf = 0;
    if (fs) begin
      if (qn == 8) begin qn = 0; e_ovf = 1; end
      else begin q[qn] = stamp_f(last_t, dsel, aud); qn++; end
    end
    e_fs = armed && ({cnt, ofs} == tgt);
    if (e_fs) armed = 0;
    if (ld) begin tgt = rx; armed = (rx != 16'hFFFF); end
    @(posedge clk);
    @(negedge clk);
    last_t = {cnt, ofs};
    if (fsync_out) pulses++;
    chk(syt_out == e_syt, tag, syt_out, e_syt);
    chk(ovf_pulse == e_ovf, tag, ovf_pulse, e_ovf);
    chk(fsync_out == e_fs, tag, fsync_out, e_fs);
  endtask

  task automatic rand_phase(string tag, int n, bit a);
    aud = a;
    for (int k = 0; k < n; k++) begin
      adv(int'($urandom_range(0, 400)));
      fs = ($urandom_range(0, 7) == 0);
      hd = $urandom_range(0, 1) == 1;
      dsel = 2'($urandom_range(0, 3));
      step(tag);
    end
    fs = 0;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(syt_out == 16'hFFFF, "R1", syt_out, 16'hFFFF);
    chk(ovf_pulse == 1'b0, "R1", ovf_pulse, 0);
    chk(fsync_out == 1'b0, "R1", fsync_out, 0);
    rst_n = 1;
    last_t = '0;

    // R2 / R9: directed stamp on each delay setting, pulse on the boundary clock
    for (int s = 0; s < 4; s++) begin
      dsel = 2'(s);
      cnt = 4'd14; ofs = 12'd3000; cs = 0; step("R2");
      ofs = 12'd3071; step("R2");
      fs = 1; adv(10); step("R9");
      fs = 0; adv(3072); step("R2");
      chk(syt_out == {4'd14 + ((s == 1) ? 4'd2 : (s == 2) ? 4'd4 : 4'd3), 12'd3071},
          "R9", syt_out, {4'd14, 12'd3071});
    end

    rand_phase("R3", 1500, 0);
    rand_phase("R4", 1500, 0);
    rand_phase("R5", 1500, 1);

    // R6: burst without emission until overflow, then normal operation
    aud = 0; cs = 0; hd = 0;
    for (int k = 0; k < 10; k++) begin fs = 1; step("R6"); end
    fs = 0;
    rand_phase("R6", 300, 0);

    // R7: receive match
    cs = 0; fs = 0; cnt = 4'd5; ofs = 12'd100;
    rx = {4'd5, 12'd103}; ld = 1; step("R7");
    ld = 0; pulses = 0;
    for (int k = 0; k < 6; k++) begin ofs = ofs + 12'd1; step("R7"); end
    chk(pulses == 1, "R7", pulses, 1);

    // R8: no-info load never fires
    rx = {4'd5, 12'd110}; ld = 1; step("R8");
    rx = 16'hFFFF; step("R8");
    ld = 0; pulses = 0;
    ofs = 12'd110; step("R8");
    cnt = 4'hF; ofs = 12'hFFF; step("R8"); step("R8");
    chk(pulses == 0, "R8", pulses, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule